// File: doc/BRIEF.md
# Tuner control I2C slave

This block is the serial control front end of a frequency-synthesiser tuner. An I2C master writes the divide ratio for the programmable divider, a control byte and a port-drive byte into it. The master can also read back one status byte, which carries the power-on flag, the lock flag, three port input levels and a 3-bit ADC code. The block runs on the system clock. SCL and the SDA line are sampled through synchronisers, and the open-drain SDA pin is driven through a single output-enable: when that enable is high, the pad pulls the line low.

A write transfer starts with the address byte. Each later data byte is classified by its first bit. A byte starting with 0 opens a divide-ratio pair, and the byte after it completes the ratio. A byte starting with 1 is a control byte, and the byte after it is the port byte. The master may keep sending such pairs until it issues a STOP. A read transfer repeats the status byte for as long as the master acknowledges. A missing acknowledge ends the read internally, and the power-on flag is cleared only by the real STOP that ends a read.

Top module: `tuner_i2c_slave`

## Requirements
- R1: The address byte is `11000` (bits 7..3), then a 2-bit match field (bits 2..1), then R/W (bit 0, 1 = read). The slave acknowledges when the match field equals `addr_sel` or equals the fixed value `01`. Otherwise it does not acknowledge, and it ignores every byte until the next START.
- R2: In a write transfer the slave pulls SDA low in the acknowledge slot of the address byte and of every data byte.
- R3: A data byte with bit 7 = 0 is the high part of a pair. Its bits 6..0 become `div_ratio[14:8]`, and the next byte becomes `div_ratio[7:0]`. The 15-bit value is committed in one step, after the second byte; it does not change after the first byte.
- R4: A data byte with bit 7 = 1, arriving when no pair is open, is stored whole in `ctrl_byte`. The next byte is stored in `port_byte`. Pairs of either kind may follow one another without a new address.
- R5: A START or STOP in the middle of a byte leaves every stored register unchanged.
- R6: The status byte, sent MSB first, is {`por_flag`, `lock_i`, `port_lvl[2:0]`, `adc_code[2:0]`}. It is captured when the transmission of that byte begins.
- R7: After a master acknowledge the status byte is sent again. After a master non-acknowledge the slave releases SDA and ignores all clocks until the next START.
- R8: `por_flag` is set by reset and by a `por_event` pulse. Only a STOP that ends a read transfer clears it; a non-acknowledge alone does not.
- R9: While `por_flag` is 1, `div_ratio`, `ctrl_byte` and `port_byte` are held at zero and writes do not change them.
- R10: `sda_oe` changes only while the synchronised SCL is low.
- R11: A repeated START restarts address decoding and closes any half-received pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| addr_sel | input | 2 | Selectable address match value |
| por_event | input | 1 | Power-on / low-supply pulse |
| lock_i | input | 1 | Phase lock flag for status |
| port_lvl | input | 3 | Port input levels for status |
| adc_code | input | 3 | ADC code for status |
| div_ratio | output | 15 | Divide ratio register |
| ctrl_byte | output | 8 | Control register |
| port_byte | output | 8 | Port drive register (1 = on) |
| por_flag | output | 1 | Power-on reset flag |

## Verification
Suppose the pairing state is wrong after a repeated START. Then the very next data byte lands in `div_ratio` instead of `ctrl_byte`, and the registers show this at the byte's acknowledge. A bit counter or shift register that is off by one shows up in the same acknowledge slot: the slot is missing, or the data byte is steered and committed with the wrong bits. A power-on flag stuck in either state appears in the MSB of the very next status byte, and also in registers that read zero after a complete write.

// File: rtl/tis_pkg.sv
package tis_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [4:0] ADDR_PREFIX = 5'b11000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_TX,
    ST_MACK,
    ST_MACK_OK
  } bus_st_e;

  typedef enum logic [1:0] {
    PAIR_NONE,
    PAIR_WANT_LO,
    PAIR_WANT_PORT
  } pair_e;
endpackage

// File: rtl/tis_rst_sync.sv
module tis_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = pipe[STAGES-1];
endmodule

// File: rtl/tis_line_sync.sv
module tis_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_d;
  logic sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tis_bus_engine.sv
module tis_bus_engine
  import tis_pkg::*;
#(
  parameter logic [1:0] FIXED_MA = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [1:0]        addr_sel,
  input  logic [BYTE_W-1:0] status_byte,
  output logic              sda_oe,
  output logic              wr_addr_ok,
  output logic              rd_addr_ok,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_dat
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  bus_st_e           st, st_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              oe, oe_n;
  logic              addr_hit;

  assign addr_hit = (sh[7:3] == ADDR_PREFIX) &&
                    ((sh[2:1] == addr_sel) || (sh[2:1] == FIXED_MA));

  always_comb begin
    st_n       = st;
    sh_n       = sh;
    cnt_n      = cnt;
    oe_n       = oe;
    wr_addr_ok = 1'b0;
    rd_addr_ok = 1'b0;
    byte_vld   = 1'b0;
    if (stop_p) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else if (start_p) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_ADDR, ST_WDATA: begin
          if (scl_rise && cnt != FULL) begin
            sh_n  = {sh[BYTE_W-2:0], sda_s};
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && cnt == FULL) begin
            if (st == ST_WDATA) begin
              byte_vld = 1'b1;
              st_n     = ST_WACK;
              oe_n     = 1'b1;
            end else if (addr_hit) begin
              st_n       = ST_AACK;
              oe_n       = 1'b1;
              rd_addr_ok = sh[0];
              wr_addr_ok = ~sh[0];
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (sh[0]) begin
              st_n = ST_TX;
              sh_n = status_byte;
              oe_n = ~status_byte[BYTE_W-1];
            end else begin
              st_n = ST_WDATA;
              oe_n = 1'b0;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            st_n  = ST_WDATA;
            cnt_n = '0;
            oe_n  = 1'b0;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == LAST) begin
              st_n = ST_MACK;
              oe_n = 1'b0;
            end else begin
              sh_n  = {sh[BYTE_W-2:0], 1'b1};
              oe_n  = ~sh[BYTE_W-2];
              cnt_n = cnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) st_n = sda_s ? ST_IDLE : ST_MACK_OK;
        end
        ST_MACK_OK: begin
          if (scl_fall) begin
            st_n  = ST_TX;
            sh_n  = status_byte;
            oe_n  = ~status_byte[BYTE_W-1];
            cnt_n = '0;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      sh  <= '0;
      cnt <= '0;
      oe  <= 1'b0;
    end else begin
      st  <= st_n;
      sh  <= sh_n;
      cnt <= cnt_n;
      oe  <= oe_n;
    end
  end

  assign sda_oe   = oe;
  assign byte_dat = sh;
endmodule

// File: rtl/tis_ctl_regs.sv
module tis_ctl_regs
  import tis_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_event,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_dat,
  input  logic              wr_addr_ok,
  input  logic              rd_addr_ok,
  input  logic              stop_p,
  output logic [DIV_W-1:0]  div_ratio,
  output logic [BYTE_W-1:0] ctrl_byte,
  output logic [BYTE_W-1:0] port_byte,
  output logic              por_flag
);
  localparam int HI_W = DIV_W - BYTE_W;

  pair_e             pair, pair_n;
  logic [HI_W-1:0]   hi, hi_n;
  logic [DIV_W-1:0]  div, div_n;
  logic [BYTE_W-1:0] ctl, ctl_n;
  logic [BYTE_W-1:0] prt, prt_n;
  logic              por, por_n;
  logic              rd_seen, rd_seen_n;

  always_comb begin
    pair_n    = pair;
    hi_n      = hi;
    div_n     = div;
    ctl_n     = ctl;
    prt_n     = prt;
    por_n     = por;
    rd_seen_n = rd_seen;
    if (wr_addr_ok) begin
      pair_n    = PAIR_NONE;
      rd_seen_n = 1'b0;
    end
    if (rd_addr_ok) rd_seen_n = 1'b1;
    if (stop_p) begin
      if (rd_seen) por_n = 1'b0;
      rd_seen_n = 1'b0;
      pair_n    = PAIR_NONE;
    end
    if (byte_vld) begin
      unique case (pair)
        PAIR_NONE: begin
          if (!byte_dat[BYTE_W-1]) begin
            hi_n   = byte_dat[HI_W-1:0];
            pair_n = PAIR_WANT_LO;
          end else begin
            ctl_n  = byte_dat;
            pair_n = PAIR_WANT_PORT;
          end
        end
        PAIR_WANT_LO: begin
          div_n  = {hi, byte_dat};
          pair_n = PAIR_NONE;
        end
        PAIR_WANT_PORT: begin
          prt_n  = byte_dat;
          pair_n = PAIR_NONE;
        end
        default: pair_n = PAIR_NONE;
      endcase
    end
    if (por_event || por) begin
      hi_n  = '0;
      div_n = '0;
      ctl_n = '0;
      prt_n = '0;
    end
    if (por_event) por_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair    <= PAIR_NONE;
      hi      <= '0;
      div     <= '0;
      ctl     <= '0;
      prt     <= '0;
      por     <= 1'b1;
      rd_seen <= 1'b0;
    end else begin
      pair    <= pair_n;
      hi      <= hi_n;
      div     <= div_n;
      ctl     <= ctl_n;
      prt     <= prt_n;
      por     <= por_n;
      rd_seen <= rd_seen_n;
    end
  end

  assign div_ratio = div;
  assign ctrl_byte = ctl;
  assign port_byte = prt;
  assign por_flag  = por;
endmodule

// File: rtl/tuner_i2c_slave.sv
module tuner_i2c_slave
  import tis_pkg::*;
#(
  parameter int         DIV_W     = 15,
  parameter int         SYNC_STG  = 2,
  parameter logic [1:0] FIXED_MA  = 2'b01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [1:0]       addr_sel,
  input  logic             por_event,
  input  logic             lock_i,
  input  logic [2:0]       port_lvl,
  input  logic [2:0]       adc_code,
  output logic [DIV_W-1:0] div_ratio,
  output logic [7:0]       ctrl_byte,
  output logic [7:0]       port_byte,
  output logic             por_flag
);
  logic              rst_n_s;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic              wr_addr_ok, rd_addr_ok, byte_vld;
  logic [BYTE_W-1:0] byte_dat;
  logic [BYTE_W-1:0] status_byte;

  assign status_byte = {por_flag, lock_i, port_lvl, adc_code};

  tis_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  tis_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  tis_bus_engine #(.FIXED_MA(FIXED_MA)) u_eng (
    .clk(clk), .rst_n(rst_n_s), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
    .addr_sel(addr_sel), .status_byte(status_byte), .sda_oe(sda_oe),
    .wr_addr_ok(wr_addr_ok), .rd_addr_ok(rd_addr_ok),
    .byte_vld(byte_vld), .byte_dat(byte_dat)
  );

  tis_ctl_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .por_event(por_event),
    .byte_vld(byte_vld), .byte_dat(byte_dat),
    .wr_addr_ok(wr_addr_ok), .rd_addr_ok(rd_addr_ok), .stop_p(stop_p),
    .div_ratio(div_ratio), .ctrl_byte(ctrl_byte), .port_byte(port_byte),
    .por_flag(por_flag)
  );
endmodule

// File: rtl/tuner_i2c_slave_chk.sv
module tuner_i2c_slave_chk #(
  parameter int DIV_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_oe,
  input logic             por_event,
  input logic             por_flag,
  input logic [DIV_W-1:0] div_ratio,
  input logic [7:0]       ctrl_byte,
  input logic [7:0]       port_byte,
  input logic             byte_vld,
  input logic             stop_p
);
  // R8
  por_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_event |=> por_flag);

  // R8
  por_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_flag) |-> $past(stop_p));

  // R9
  por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_flag |-> (div_ratio == '0 && ctrl_byte == 8'h00 && port_byte == 8'h00));

  // R3
  div_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_ratio) |-> ($past(byte_vld) || $past(por_event)));

  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
endmodule

bind tuner_i2c_slave tuner_i2c_slave_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .por_event(por_event), .por_flag(por_flag), .div_ratio(div_ratio),
  .ctrl_byte(ctrl_byte), .port_byte(port_byte), .byte_vld(byte_vld),
  .stop_p(stop_p)
);

// File: tb/tb_tuner_i2c_slave.sv
module tb_tuner_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 6;
  localparam int NVEC       = 9;

  // {addr_sel, address byte, expected ack}
  localparam logic [10:0] ADDR_VEC [NVEC] = '{
    {2'b00, 8'hC2, 1'b1}, {2'b00, 8'hC0, 1'b1}, {2'b00, 8'hC4, 1'b0},
    {2'b10, 8'hC4, 1'b1}, {2'b10, 8'hC6, 1'b0}, {2'b11, 8'hC6, 1'b1},
    {2'b11, 8'hC0, 1'b0}, {2'b01, 8'hC2, 1'b1}, {2'b00, 8'hA2, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  addr_sel = 2'b00;
  logic        por_event = 1'b0;
  logic        lock_i = 1'b0;
  logic [2:0]  port_lvl = 3'b000;
  logic [2:0]  adc_code = 3'b000;
  logic        sda_oe;
  logic [14:0] div_ratio;
  logic [7:0]  ctrl_byte, port_byte;
  logic        por_flag;
  wire         sda_line = sda_m & ~sda_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tuner_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .addr_sel(addr_sel), .por_event(por_event),
    .lock_i(lock_i), .port_lvl(port_lvl), .adc_code(adc_code),
    .div_ratio(div_ratio), .ctrl_byte(ctrl_byte), .port_byte(port_byte),
    .por_flag(por_flag)
  );

  task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic recv_bit(output logic b, output logic oe_a, output logic oe_b);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    b = sda_line; oe_a = sda_oe;
    qwait();
    oe_b = sda_oe;
    scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b, oa, ob;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b, oa, ob);
    check_val("R10 sda_oe steady while SCL high", {31'd0, ob}, {31'd0, oa});
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d);
    logic oa, ob;
    for (int i = 7; i >= 0; i--) recv_bit(d[i], oa, ob);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] rd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Reset state
    check_val("R8 por after reset", {31'd0, por_flag}, 32'd1);
    check_val("R9 div after reset", {17'd0, div_ratio}, 32'd0);
    check_val("R9 ctrl/port after reset", {16'd0, ctrl_byte, port_byte}, 32'd0);
    check_val("R10 sda idle", {31'd0, sda_oe}, 32'd0);

    // Writes while POR set are acked but ignored
    bus_start();
    send_byte(8'hC2, ack); check_val("R1 addr ack", {31'd0, ack}, 32'd1);
    send_byte(8'h12, ack); check_val("R2 data ack", {31'd0, ack}, 32'd1);
    send_byte(8'h34, ack); check_val("R2 data ack 2", {31'd0, ack}, 32'd1);
    bus_stop();
    check_val("R9 write ignored while por", {17'd0, div_ratio}, 32'd0);
    check_val("R8 write stop keeps por", {31'd0, por_flag}, 32'd1);

    // Read status with POR set, then STOP clears POR
    lock_i = 1'b0; port_lvl = 3'b010; adc_code = 3'b100;
    bus_start();
    send_byte(8'hC3, ack); check_val("R1 read addr ack", {31'd0, ack}, 32'd1);
    recv_byte(rd); check_val("R6 status with por", {24'd0, rd}, 32'h94);
    send_bit(1'b1);
    bus_stop();
    check_val("R8 por cleared by read stop", {31'd0, por_flag}, 32'd0);

    // Address table
    for (int i = 0; i < NVEC; i++) begin
      addr_sel = ADDR_VEC[i][10:9];
      bus_start();
      send_byte(ADDR_VEC[i][8:1], ack);
      check_val($sformatf("R1 addr vec %0d", i), {31'd0, ack}, {31'd0, ADDR_VEC[i][0]});
      bus_stop();
    end

    // Unmatched address: later bytes ignored
    addr_sel = 2'b00;
    bus_start();
    send_byte(8'hC4, ack);
    send_byte(8'h11, ack); check_val("R1 byte after miss not acked", {31'd0, ack}, 32'd0);
    send_byte(8'h22, ack);
    bus_stop();
    check_val("R1 miss leaves div", {17'd0, div_ratio}, 32'd0);

    // Divide-ratio pair, then control/port, then another pair
    bus_start();
    send_byte(8'hC2, ack);
    send_byte(8'h2A, ack);
    check_val("R3 div unchanged after high byte", {17'd0, div_ratio}, 32'd0);
    send_byte(8'h5B, ack);
    check_val("R3 div committed", {17'd0, div_ratio}, 32'h2A5B);
    check_val("R3 ctrl untouched", {24'd0, ctrl_byte}, 32'd0);
    send_byte(8'hCE, ack);
    check_val("R4 ctrl stored", {24'd0, ctrl_byte}, 32'hCE);
    send_byte(8'h81, ack);
    check_val("R4 port stored", {24'd0, port_byte}, 32'h81);
    send_byte(8'h01, ack);
    send_byte(8'h00, ack);
    check_val("R4 pair without readdress", {17'd0, div_ratio}, 32'h0100);
    bus_stop();

    // Partial bytes
    bus_start();
    send_byte(8'hC2, ack);
    send_byte(8'h03, ack);
    for (int i = 7; i >= 4; i--) send_bit(1'(8'h12 >> i));
    bus_stop();
    check_val("R5 partial low byte", {17'd0, div_ratio}, 32'h0100);
    bus_start();
    send_byte(8'hC2, ack);
    for (int i = 7; i >= 3; i--) send_bit(1'(8'h8C >> i));
    bus_stop();
    check_val("R5 partial ctrl byte", {24'd0, ctrl_byte}, 32'hCE);

    // Repeated START closes half pair
    bus_start();
    send_byte(8'hC2, ack);
    send_byte(8'h7F, ack);
    bus_start();
    send_byte(8'hC2, ack); check_val("R11 readdress ack", {31'd0, ack}, 32'd1);
    send_byte(8'h90, ack);
    check_val("R11 fresh pair ctrl", {24'd0, ctrl_byte}, 32'h90);
    check_val("R11 div untouched", {17'd0, div_ratio}, 32'h0100);
    send_byte(8'h00, ack);
    check_val("R4 port cleared", {24'd0, port_byte}, 32'h00);
    bus_stop();

    // Repeated status reads
    lock_i = 1'b1; port_lvl = 3'b101; adc_code = 3'b011;
    bus_start();
    send_byte(8'hC3, ack);
    recv_byte(rd); check_val("R6 status", {24'd0, rd}, 32'h6B);
    lock_i = 1'b0; port_lvl = 3'b111; adc_code = 3'b000;
    send_bit(1'b0);
    recv_byte(rd); check_val("R7 status resent after ack", {24'd0, rd}, 32'h38);
    send_bit(1'b1);
    recv_byte(rd); check_val("R7 released after nack", {24'd0, rd}, 32'hFF);
    bus_stop();

    // POR event
    @(negedge clk); por_event = 1'b1;
    @(negedge clk); por_event = 1'b0;
    @(negedge clk);
    check_val("R8 por event sets flag", {31'd0, por_flag}, 32'd1);
    check_val("R9 regs cleared", {1'b0, div_ratio, ctrl_byte, port_byte}, 32'd0);
    bus_start();
    send_byte(8'hC3, ack);
    recv_byte(rd); check_val("R6 por bit in status", {31'd0, rd[7]}, 32'd1);
    send_bit(1'b1);
    check_val("R8 nack alone keeps por", {31'd0, por_flag}, 32'd1);
    bus_stop();
    check_val("R8 stop clears por", {31'd0, por_flag}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule